// File: doc/BRIEF.md
# Header rewrite action unit

The unit sits between a match-action lookup and a deparser. It accepts one parsed header vector per transfer. Each vector carries the Ethernet addresses, an optional VLAN tag, an optional IPv4 TTL and header checksum, a valid bit for each optional header, and the action code and parameters that the lookup picked. The unit applies that action and presents the rewritten vector one cycle later.

A route action puts the supplied addresses into the Ethernet destination and source fields. It writes the supplied VLAN ID into the VID field, but only when a VLAN tag is present. When an IPv4 header is present, it lowers the TTL by one and repairs the header checksum incrementally. The checksum repair needs only the old checksum, so the other IPv4 words never have to enter the unit. A TTL that is already 0 or 1 marks the packet as expired, and a TTL of zero is left at zero. Every other action code passes the vector through untouched.

Both sides use a valid/ready handshake. A single register stage holds the result, and that stage stalls whenever the output is backpressured.

Top module: `hdr_rewrite_unit`

## Requirements
- R1: After reset the output valid is low, the input ready is high and every output data field is zero.
- R2: A vector accepted on a clock edge (input valid and ready both high) appears at the output, with the output valid high, right after that edge.
- R3: While the output valid is high and the output ready is low, the output holds all its fields and the input ready is low. Otherwise the input ready is high.
- R4: Under action code 1 (route), the output destination and source MAC equal the destination and source MAC parameters.
- R5: Under route, the output VID equals the VID parameter if the VLAN valid bit is set. Otherwise it equals the input VID.
- R6: Under route with the IPv4 valid bit set and an input TTL of 1 or more, the output TTL is the input TTL minus one. With the IPv4 valid bit clear, the TTL and checksum are passed unchanged.
- R7: When the TTL changes, the output checksum equals the ones-complement header checksum recomputed with the new TTL, the TTL being the high byte of its 16-bit header word. When the TTL does not change, the checksum is passed unchanged.
- R8: Under route with the IPv4 valid bit set, an input TTL of 0 or 1 raises the expire output. An input TTL of 0 leaves the output TTL at 0. Expire is low in every other case.
- R9: Action code 0 (no-op), and the unused codes 2 and 3, pass every header field through unchanged.
- R10: The VLAN and IPv4 valid bits pass to the output unchanged under every action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input vector valid |
| in_ready_o | output | 1 | Unit can accept a vector |
| in_act_i | input | 2 | Action code: 0 no-op, 1 route, 2 and 3 treated as no-op |
| in_dmac_prm_i | input | 48 | Route parameter: new destination MAC |
| in_smac_prm_i | input | 48 | Route parameter: new source MAC |
| in_vid_prm_i | input | 12 | Route parameter: new VLAN ID |
| in_eth_dst_i | input | 48 | Ethernet destination MAC |
| in_eth_src_i | input | 48 | Ethernet source MAC |
| in_vlan_vld_i | input | 1 | VLAN tag present |
| in_vlan_vid_i | input | 12 | VLAN ID |
| in_ipv4_vld_i | input | 1 | IPv4 header present |
| in_ipv4_ttl_i | input | 8 | IPv4 TTL |
| in_ipv4_csum_i | input | 16 | IPv4 header checksum |
| out_valid_o | output | 1 | Output vector valid |
| out_ready_i | input | 1 | Downstream accepts the vector |
| out_eth_dst_o | output | 48 | Rewritten destination MAC |
| out_eth_src_o | output | 48 | Rewritten source MAC |
| out_vlan_vld_o | output | 1 | VLAN tag present |
| out_vlan_vid_o | output | 12 | Rewritten VLAN ID |
| out_ipv4_vld_o | output | 1 | IPv4 header present |
| out_ipv4_ttl_o | output | 8 | Rewritten TTL |
| out_ipv4_csum_o | output | 16 | Repaired header checksum |
| out_expire_o | output | 1 | TTL expired on a routed IPv4 packet |

## Verification
The checksum properties assume that each arriving IPv4 checksum is correct for its own header. The bench therefore builds every IPv4 header in full, with random words and protocol byte, computes the checksum itself and drives only the TTL and checksum. The properties place no demand on input data being held during a stall. The bench redrives fresh random vectors on every cycle, including stalled ones, and covers TTLs of 0, 1, 2 and 255 as well as the unused action codes and headers without valid bits. Output ready is mostly random, with stretches held low, so that stalls and back-to-back transfers both occur.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int TTL_W  = 8;
  localparam int CSUM_W = 16;
  localparam int ACT_W  = 2;

  localparam logic [ACT_W-1:0] ACT_NOP   = 'd0;
  localparam logic [ACT_W-1:0] ACT_ROUTE = 'd1;

  // checksum word change caused by TTL - 1, TTL in the high byte
  localparam logic [CSUM_W-1:0] TTL_DEC_DELTA = ~(CSUM_W'(1) << (CSUM_W - TTL_W));

  typedef struct packed {
    logic [MAC_W-1:0]  dst;
    logic [MAC_W-1:0]  src;
    logic              vlan_vld;
    logic [VID_W-1:0]  vid;
    logic              ip_vld;
    logic [TTL_W-1:0]  ttl;
    logic [CSUM_W-1:0] csum;
    logic              expire;
  } hdr_t;

  function automatic logic [CSUM_W-1:0] oc_add(logic [CSUM_W-1:0] a, logic [CSUM_W-1:0] b);
    logic [CSUM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, s[CSUM_W]};
  endfunction
endpackage

// File: rtl/hdr_l2_rewrite.sv
module hdr_l2_rewrite
  import hdr_pkg::*;
(
  input  logic             route_i,
  input  logic [MAC_W-1:0] dst_i,
  input  logic [MAC_W-1:0] src_i,
  input  logic             vlan_vld_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic [MAC_W-1:0] dmac_prm_i,
  input  logic [MAC_W-1:0] smac_prm_i,
  input  logic [VID_W-1:0] vid_prm_i,
  output logic [MAC_W-1:0] dst_o,
  output logic [MAC_W-1:0] src_o,
  output logic [VID_W-1:0] vid_o
);
  always_comb begin
    dst_o = route_i ? dmac_prm_i : dst_i;
    src_o = route_i ? smac_prm_i : src_i;
    vid_o = (route_i && vlan_vld_i) ? vid_prm_i : vid_i;
  end
endmodule

// File: rtl/hdr_ttl_update.sv
module hdr_ttl_update
  import hdr_pkg::*;
(
  input  logic              route_i,
  input  logic              ip_vld_i,
  input  logic [TTL_W-1:0]  ttl_i,
  input  logic [CSUM_W-1:0] csum_i,
  output logic [TTL_W-1:0]  ttl_o,
  output logic [CSUM_W-1:0] csum_o,
  output logic              expire_o
);
  logic act;
  logic ttl_zero;
  logic dec;

  always_comb begin
    act      = route_i && ip_vld_i;
    ttl_zero = (ttl_i == '0);
    dec      = act && !ttl_zero;
    expire_o = act && (ttl_i <= TTL_W'(1));
    ttl_o    = dec ? ttl_i - TTL_W'(1) : ttl_i;
    // HC' = ~(~HC + ~m + m'), where ~m + m' reduces to TTL_DEC_DELTA
    csum_o   = dec ? ~oc_add(~csum_i, TTL_DEC_DELTA) : csum_i;
  end
endmodule

// File: rtl/hdr_out_reg.sv
module hdr_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] d_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] q_o
);
  logic load;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      q_o         <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (load)       q_o         <= d_i;
    end
  end
endmodule

// File: rtl/hdr_rewrite_unit.sv
module hdr_rewrite_unit
  import hdr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ACT_W-1:0]  in_act_i,
  input  logic [MAC_W-1:0]  in_dmac_prm_i,
  input  logic [MAC_W-1:0]  in_smac_prm_i,
  input  logic [VID_W-1:0]  in_vid_prm_i,
  input  logic [MAC_W-1:0]  in_eth_dst_i,
  input  logic [MAC_W-1:0]  in_eth_src_i,
  input  logic              in_vlan_vld_i,
  input  logic [VID_W-1:0]  in_vlan_vid_i,
  input  logic              in_ipv4_vld_i,
  input  logic [TTL_W-1:0]  in_ipv4_ttl_i,
  input  logic [CSUM_W-1:0] in_ipv4_csum_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [MAC_W-1:0]  out_eth_dst_o,
  output logic [MAC_W-1:0]  out_eth_src_o,
  output logic              out_vlan_vld_o,
  output logic [VID_W-1:0]  out_vlan_vid_o,
  output logic              out_ipv4_vld_o,
  output logic [TTL_W-1:0]  out_ipv4_ttl_o,
  output logic [CSUM_W-1:0] out_ipv4_csum_o,
  output logic              out_expire_o
);
  localparam int HW = $bits(hdr_t);

  logic route;
  hdr_t nxt;
  hdr_t cur;

  assign route = (in_act_i == ACT_ROUTE);

  hdr_l2_rewrite u_l2 (
    .route_i   (route),
    .dst_i     (in_eth_dst_i),
    .src_i     (in_eth_src_i),
    .vlan_vld_i(in_vlan_vld_i),
    .vid_i     (in_vlan_vid_i),
    .dmac_prm_i(in_dmac_prm_i),
    .smac_prm_i(in_smac_prm_i),
    .vid_prm_i (in_vid_prm_i),
    .dst_o     (nxt.dst),
    .src_o     (nxt.src),
    .vid_o     (nxt.vid)
  );

  hdr_ttl_update u_ttl (
    .route_i (route),
    .ip_vld_i(in_ipv4_vld_i),
    .ttl_i   (in_ipv4_ttl_i),
    .csum_i  (in_ipv4_csum_i),
    .ttl_o   (nxt.ttl),
    .csum_o  (nxt.csum),
    .expire_o(nxt.expire)
  );

  assign nxt.vlan_vld = in_vlan_vld_i;
  assign nxt.ip_vld   = in_ipv4_vld_i;

  hdr_out_reg #(.W(HW)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .d_i        (nxt),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .q_o        (cur)
  );

  assign out_eth_dst_o   = cur.dst;
  assign out_eth_src_o   = cur.src;
  assign out_vlan_vld_o  = cur.vlan_vld;
  assign out_vlan_vid_o  = cur.vid;
  assign out_ipv4_vld_o  = cur.ip_vld;
  assign out_ipv4_ttl_o  = cur.ttl;
  assign out_ipv4_csum_o = cur.csum;
  assign out_expire_o    = cur.expire;
endmodule

// File: rtl/hdr_rewrite_chk.sv
module hdr_rewrite_chk
  import hdr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [ACT_W-1:0]  in_act_i,
  input logic [MAC_W-1:0]  in_dmac_prm_i,
  input logic [MAC_W-1:0]  in_smac_prm_i,
  input logic [VID_W-1:0]  in_vid_prm_i,
  input logic [MAC_W-1:0]  in_eth_dst_i,
  input logic [MAC_W-1:0]  in_eth_src_i,
  input logic              in_vlan_vld_i,
  input logic [VID_W-1:0]  in_vlan_vid_i,
  input logic              in_ipv4_vld_i,
  input logic [TTL_W-1:0]  in_ipv4_ttl_i,
  input logic [CSUM_W-1:0] in_ipv4_csum_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [MAC_W-1:0]  out_eth_dst_o,
  input logic [MAC_W-1:0]  out_eth_src_o,
  input logic              out_vlan_vld_o,
  input logic [VID_W-1:0]  out_vlan_vid_o,
  input logic              out_ipv4_vld_o,
  input logic [TTL_W-1:0]  out_ipv4_ttl_o,
  input logic [CSUM_W-1:0] out_ipv4_csum_o,
  input logic              out_expire_o
);
  logic fire;
  assign fire = in_valid_i && in_ready_o;

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_eth_dst_o)
      && $stable(out_ipv4_ttl_o) && $stable(out_ipv4_csum_o) && $stable(out_expire_o)));

  p_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  p_mac_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_act_i == ACT_ROUTE) |=>
      (out_eth_dst_o == $past(in_dmac_prm_i) && out_eth_src_o == $past(in_smac_prm_i)));

  p_vid_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !in_vlan_vld_i) |=> out_vlan_vid_o == $past(in_vlan_vid_i));

  p_ttl_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_act_i == ACT_ROUTE && in_ipv4_vld_i && in_ipv4_ttl_i != '0) |=>
      out_ipv4_ttl_o == $past(in_ipv4_ttl_i) - TTL_W'(1));

  p_csum_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (in_act_i != ACT_ROUTE || !in_ipv4_vld_i || in_ipv4_ttl_i == '0)) |=>
      out_ipv4_csum_o == $past(in_ipv4_csum_i));

  p_expire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_expire_o) |-> (out_ipv4_ttl_o == '0 && out_ipv4_vld_o));

  p_nop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_act_i != ACT_ROUTE) |=>
      (out_eth_dst_o == $past(in_eth_dst_i) && out_eth_src_o == $past(in_eth_src_i)
       && !out_expire_o));

  p_valid_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (out_vlan_vld_o == $past(in_vlan_vld_i) && out_ipv4_vld_o == $past(in_ipv4_vld_i)));
endmodule

bind hdr_rewrite_unit hdr_rewrite_chk u_chk (.*);

// File: tb/tb_hdr_rewrite_unit.sv
module tb_hdr_rewrite_unit;
  localparam time CLK_P = 8ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [1:0]  in_act = '0;
  logic [47:0] dmac_prm = '0, smac_prm = '0, eth_dst = '0, eth_src = '0;
  logic [11:0] vid_prm = '0, vid = '0;
  logic        vlan_vld = 1'b0, ip_vld = 1'b0;
  logic [7:0]  ttl = '0;
  logic [15:0] csum = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [47:0] o_dst, o_src;
  logic        o_vlan_vld, o_ip_vld, o_expire;
  logic [11:0] o_vid;
  logic [7:0]  o_ttl;
  logic [15:0] o_csum;

  hdr_rewrite_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_act_i(in_act),
    .in_dmac_prm_i(dmac_prm), .in_smac_prm_i(smac_prm), .in_vid_prm_i(vid_prm),
    .in_eth_dst_i(eth_dst), .in_eth_src_i(eth_src),
    .in_vlan_vld_i(vlan_vld), .in_vlan_vid_i(vid),
    .in_ipv4_vld_i(ip_vld), .in_ipv4_ttl_i(ttl), .in_ipv4_csum_i(csum),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_eth_dst_o(o_dst), .out_eth_src_o(o_src),
    .out_vlan_vld_o(o_vlan_vld), .out_vlan_vid_o(o_vid),
    .out_ipv4_vld_o(o_ip_vld), .out_ipv4_ttl_o(o_ttl),
    .out_ipv4_csum_o(o_csum), .out_expire_o(o_expire)
  );

  typedef struct {
    logic [47:0] dst, src;
    logic        vv, iv, exp;
    logic [11:0] vid;
    logic [7:0]  ttl;
    logic [15:0] csum;
    string       tag;
  } rec_t;

  rec_t exp_q[$];
  int   checks = 0;
  int   errors = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  // full ones-complement header checksum from its words, TTL in the high byte
  function automatic logic [15:0] hdr_csum(logic [15:0] w[8], logic [7:0] t, logic [7:0] p);
    int s = 0;
    foreach (w[i]) s += int'(w[i]);
    s += int'({t, p});
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  function automatic logic [47:0] rnd48();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[47:0];
  endfunction

  task automatic cyc(bit v, bit [1:0] a, bit vvb, bit ivb, bit [7:0] t, bit ordy);
    logic [15:0] w[8];
    logic [7:0]  p;
    rec_t        e;
    bit          route, in_fire, out_fire;
    @(negedge clk);
    foreach (w[i]) w[i] = 16'($urandom());
    p        = 8'($urandom());
    in_valid = v;  in_act = a;  vlan_vld = vvb;  ip_vld = ivb;  ttl = t;
    dmac_prm = rnd48(); smac_prm = rnd48(); eth_dst = rnd48(); eth_src = rnd48();
    vid_prm  = 12'($urandom()); vid = 12'($urandom());
    csum     = hdr_csum(w, t, p);
    out_ready = ordy;
    #1;
    chk("R2 out_valid", 64'(out_valid), 64'(exp_q.size() != 0));
    chk("R3 in_ready", 64'(in_ready), 64'(exp_q.size() == 0 || ordy));
    if (out_valid && exp_q.size() != 0) begin
      e = exp_q[0];
      chk({e.tag, " dst"},  64'(o_dst),  64'(e.dst));
      chk({e.tag, " src"},  64'(o_src),  64'(e.src));
      chk("R5 vid",         64'(o_vid),  64'(e.vid));
      chk("R6 ttl",         64'(o_ttl),  64'(e.ttl));
      chk("R7 csum",        64'(o_csum), 64'(e.csum));
      chk("R8 expire",      64'(o_expire), 64'(e.exp));
      chk("R10 valid bits", 64'({o_vlan_vld, o_ip_vld}), 64'({e.vv, e.iv}));
    end
    out_fire = (exp_q.size() != 0) && ordy;
    in_fire  = v && (exp_q.size() == 0 || ordy);
    if (out_fire) void'(exp_q.pop_front());
    if (in_fire) begin
      route  = (a == 2'd1);
      e.tag  = route ? "R4" : "R9";
      e.dst  = route ? dmac_prm : eth_dst;
      e.src  = route ? smac_prm : eth_src;
      e.vid  = (route && vvb) ? vid_prm : vid;
      e.vv   = vvb;
      e.iv   = ivb;
      e.ttl  = (route && ivb && t != 0) ? t - 8'd1 : t;
      e.csum = (e.ttl != t) ? hdr_csum(w, e.ttl, p) : csum;
      e.exp  = route && ivb && (t <= 8'd1);
      exp_q.push_back(e);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 data", 64'(o_dst ^ o_src ^ 48'(o_ttl) ^ 48'(o_csum) ^ 48'(o_vid)), 64'd0);
    chk("R1 expire", 64'(o_expire), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // directed: TTL corners under route
    cyc(1, 1, 1, 1, 8'd2,   1);
    cyc(1, 1, 1, 1, 8'd1,   1);
    cyc(1, 1, 1, 1, 8'd0,   1);
    cyc(1, 1, 0, 1, 8'd255, 1);
    cyc(1, 1, 1, 0, 8'd0,   1);
    cyc(1, 1, 0, 0, 8'd64,  1);
    // no-op and unused codes
    cyc(1, 0, 1, 1, 8'd1,   1);
    cyc(1, 2, 1, 1, 8'd0,   1);
    cyc(1, 3, 1, 1, 8'd9,   1);
    // stall window with input still presented
    cyc(1, 1, 1, 1, 8'd7,   0);
    cyc(1, 0, 1, 1, 8'd7,   0);
    cyc(1, 1, 0, 1, 8'd3,   0);
    cyc(0, 1, 0, 1, 8'd3,   1);
    cyc(0, 1, 0, 1, 8'd3,   1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] t;
      case ($urandom_range(0, 5))
        0: t = 8'd0;
        1: t = 8'd1;
        2: t = 8'd255;
        default: t = 8'($urandom());
      endcase
      cyc($urandom_range(0, 3) != 0, 2'($urandom()), 1'($urandom()), 1'($urandom()),
          t, (i % 200 > 180) ? 1'b0 : ($urandom_range(0, 9) < 7));
    end
    cyc(0, 0, 0, 0, 8'd0, 1);
    cyc(0, 0, 0, 0, 8'd0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule